// File: doc/BRIEF.md
# Word Reservation Monitor for Load-Reserve / Store-Conditional

This block holds the single reservation that a processor core needs in order to run an atomic read-modify-write sequence built from a load-and-reserve word operation and a store-conditional word operation. A load-reserve request forms an effective address from the two register operands and reads a 32-bit word from memory. It returns that word zero-extended to 64 bits and records a reservation. The reservation holds a valid flag, a length of four bytes, and the address. Addresses are not translated, so the real address is the effective address.

A store-conditional request forms its address the same way and then decides whether the store may go ahead. The store goes ahead only while a four-byte reservation is held at exactly that address. When it goes ahead, the block raises the memory write strobe in the request cycle and drives the low 32 bits of the source operand as write data. The block then returns a 4-bit condition field made of the success bit and the incoming summary-overflow bit. Every store-conditional drops the reservation, whether or not it wrote. A mismatched address that lies in the same page as the reservation is flagged inside the block as the implementation-defined case. That case is resolved as a failed store.

Requests are single-cycle pulses, and a load and a store-conditional never arrive in the same cycle. Memory reads are combinational within the request cycle. The loaded value, the condition field and a done pulse appear one cycle after the request.

Top module: `lrsc_monitor`

## Requirements
- R1: The access address on `mem_addr` during a request cycle equals `rb_val` plus `ra_val`, modulo 2^64. When `ra_zero` is 1, zero replaces `ra_val`.
- R2: A load-reserve raises `mem_re` in its request cycle, with `mem_we` at 0. One cycle later `rt_data` holds 32 zero bits above the 32-bit `mem_rdata` sampled in the request cycle.
- R3: A load-reserve records a held reservation of length 4 at the request's address. A load that follows an earlier one replaces the earlier reservation.
- R4: A store-conditional raises `mem_we` in its request cycle, with `mem_wdata` equal to `rs_val[31:0]`, only when a reservation of length 4 is held at exactly the request's address.
- R5: A store-conditional whose address differs from the held reservation performs no store and reports failure. This holds whether or not the two addresses share a page of `PAGE_BYTES` bytes (default 4096).
- R6: A store-conditional issued with no reservation held performs no store and reports failure.
- R7: One cycle after a store-conditional, `cr_field` is {2'b00, success, so_in}. Bit 1 is the success bit and bit 0 is `so_in` as sampled in the request cycle.
- R8: Every store-conditional clears the reservation, so an immediately repeated store-conditional to the same address fails.
- R9: `done` is high for exactly the one cycle after each request and low otherwise.
- R10: Synchronous active-high `rst` clears the reservation, `done`, `cr_field` and `rt_data`. A request arriving in a reset cycle leaves no reservation behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load-reserve request pulse |
| sc_valid | input | 1 | Store-conditional request pulse |
| ra_zero | input | 1 | Use zero in place of the RA operand |
| ra_val | input | 64 | RA operand value |
| rb_val | input | 64 | RB operand value |
| rs_val | input | 64 | Source operand for the conditional store |
| so_in | input | 1 | Summary-overflow bit |
| mem_addr | output | 64 | Memory access address |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 32 | Word returned by memory in the same cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Word to be written |
| done | output | 1 | Result-valid pulse |
| cr_field | output | 4 | Condition field result of the last store-conditional |
| rt_data | output | 64 | Zero-extended word from the last load-reserve |

## Verification
Two functions can land in the same clock edge: the reset that clears the reservation and a load-reserve that tries to set it. The bench raises `rst` while it drives a load-reserve pulse. It then releases reset and issues a store-conditional to the same address. A correct design reports failure and raises no write strobe, because reset has to win. A second overlap is a store-conditional that judges the reservation and clears it in the same edge. The bench probes this with two back-to-back store-conditionals after a single load. Only the first may succeed.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    localparam int unsigned XLEN      = 64;
    localparam int unsigned WORD_BITS = 32;
    localparam int unsigned LEN_BITS  = 4;
    localparam int unsigned CR_BITS   = 4;

    localparam logic [LEN_BITS-1:0] WORD_RESV_LEN = LEN_BITS'(4);

    typedef enum logic [1:0] {
        REQ_IDLE = 2'd0,
        REQ_LOAD = 2'd1,
        REQ_STCX = 2'd2
    } req_e;

    typedef struct packed {
        logic                held;
        logic [LEN_BITS-1:0] len;
        logic [XLEN-1:0]     addr;
    } resv_t;

    localparam resv_t RESV_EMPTY = '{held: 1'b0, len: '0, addr: '0};

    function automatic logic [CR_BITS-1:0] cr_pack(input logic ok, input logic so);
        return {2'b00, ok, so};
    endfunction

    function automatic logic [XLEN-1:0] zext_word(input logic [WORD_BITS-1:0] w);
        return {{(XLEN-WORD_BITS){1'b0}}, w};
    endfunction

endpackage

// File: rtl/lrsc_ea_gen.sv
module lrsc_ea_gen
    import lrsc_pkg::*;
(
    input  logic            base_is_zero,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] index_val,
    output logic [XLEN-1:0] ea
);
    logic [XLEN-1:0] base_eff;

    always_comb begin
        base_eff = base_is_zero ? '0 : base_val;
        ea       = base_eff + index_val;
    end
endmodule

// File: rtl/lrsc_resv_store.sv
module lrsc_resv_store
    import lrsc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            set_en,
    input  logic            clr_en,
    input  logic [XLEN-1:0] set_addr,
    output resv_t           resv
);
    resv_t resv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            resv_q <= RESV_EMPTY;
        end else if (set_en) begin
            resv_q.held <= 1'b1;
            resv_q.len  <= WORD_RESV_LEN;
            resv_q.addr <= set_addr;
        end else if (clr_en) begin
            resv_q.held <= 1'b0;
        end
    end

    assign resv = resv_q;

    AST_RESET_DROPS: assert property (@(posedge clk) rst |=> !resv_q.held); // R10
    AST_SET_RECORDS: assert property (@(posedge clk) disable iff (rst)
        set_en |=> (resv_q.held && resv_q.len == WORD_RESV_LEN && resv_q.addr == $past(set_addr))); // R3
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set_en) |=> !resv_q.held); // R8
endmodule

// File: rtl/lrsc_stcx_judge.sv
module lrsc_stcx_judge
    import lrsc_pkg::*;
#(
    parameter int unsigned PAGE_SHIFT = 12
)(
    input  resv_t           resv,
    input  logic [XLEN-1:0] ea,
    output logic            pass,
    output logic            same_page
);
    logic exact;
    logic page_eq;

    always_comb begin
        exact = resv.held && (resv.len == WORD_RESV_LEN) && (resv.addr == ea);
        pass  = exact;
    end

    generate
        if (PAGE_SHIFT == 0) begin : g_byte_pages
            assign page_eq = (resv.addr == ea);
        end else if (PAGE_SHIFT >= XLEN) begin : g_one_page
            assign page_eq = 1'b1;
        end else begin : g_paged
            assign page_eq = (resv.addr[XLEN-1:PAGE_SHIFT] == ea[XLEN-1:PAGE_SHIFT]);
        end
    endgenerate

    assign same_page = resv.held && !exact && page_eq;
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int unsigned PAGE_BYTES = 4096
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld_valid,
    input  logic                 sc_valid,
    input  logic                 ra_zero,
    input  logic [XLEN-1:0]      ra_val,
    input  logic [XLEN-1:0]      rb_val,
    input  logic [XLEN-1:0]      rs_val,
    input  logic                 so_in,
    output logic [XLEN-1:0]      mem_addr,
    output logic                 mem_re,
    input  logic [WORD_BITS-1:0] mem_rdata,
    output logic                 mem_we,
    output logic [WORD_BITS-1:0] mem_wdata,
    output logic                 done,
    output logic [CR_BITS-1:0]   cr_field,
    output logic [XLEN-1:0]      rt_data
);
    localparam int unsigned PAGE_SHIFT = $clog2(PAGE_BYTES);

    req_e            req;
    logic [XLEN-1:0] ea;
    resv_t           resv;
    logic            sc_pass;
    logic            sc_same_page;

    logic                 done_q;
    logic [CR_BITS-1:0]   cr_q;
    logic [XLEN-1:0]      rt_q;

    always_comb begin
        if (ld_valid)      req = REQ_LOAD;
        else if (sc_valid) req = REQ_STCX;
        else               req = REQ_IDLE;
    end

    lrsc_ea_gen u_ea (
        .base_is_zero (ra_zero),
        .base_val     (ra_val),
        .index_val    (rb_val),
        .ea           (ea)
    );

    lrsc_resv_store u_resv (
        .clk      (clk),
        .rst      (rst),
        .set_en   (req == REQ_LOAD),
        .clr_en   (req == REQ_STCX),
        .set_addr (ea),
        .resv     (resv)
    );

    lrsc_stcx_judge #(.PAGE_SHIFT(PAGE_SHIFT)) u_judge (
        .resv      (resv),
        .ea        (ea),
        .pass      (sc_pass),
        .same_page (sc_same_page)
    );

    always_comb begin
        mem_addr  = ea;
        mem_re    = (req == REQ_LOAD);
        mem_we    = (req == REQ_STCX) && sc_pass;
        mem_wdata = rs_val[WORD_BITS-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            cr_q   <= '0;
            rt_q   <= '0;
        end else begin
            done_q <= (req != REQ_IDLE);
            case (req)
                REQ_LOAD: rt_q <= zext_word(mem_rdata);
                REQ_STCX: cr_q <= cr_pack(sc_pass, so_in);
                default: ;
            endcase
        end
    end

    assign done     = done_q;
    assign cr_field = cr_q;
    assign rt_data  = rt_q;

    AST_ONE_REQUEST:  assert property (@(posedge clk) disable iff (rst) !(ld_valid && sc_valid)); // R9
    AST_DONE_AFTER:   assert property (@(posedge clk) disable iff (rst) (ld_valid || sc_valid) |=> done); // R9
    AST_DONE_QUIET:   assert property (@(posedge clk) disable iff (rst) !(ld_valid || sc_valid) |=> !done); // R9
    AST_WRITE_HELD:   assert property (@(posedge clk) disable iff (rst) mem_we |-> (resv.held && resv.addr == mem_addr)); // R4
    AST_NO_RESV_NOWR: assert property (@(posedge clk) disable iff (rst) (sc_valid && !resv.held) |-> !mem_we); // R6
    AST_PAGE_NOWR:    assert property (@(posedge clk) disable iff (rst) sc_same_page |-> !mem_we); // R5
    AST_CR_UPPER:     assert property (@(posedge clk) disable iff (rst) done |-> (cr_field[3:2] == 2'b00)); // R7
    AST_CR_SO:        assert property (@(posedge clk) disable iff (rst) sc_valid |=> (cr_field[0] == $past(so_in))); // R7
endmodule

// File: tb/tb_lrsc_monitor.sv
module tb_lrsc_monitor;
    import lrsc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ld_valid = 1'b0, sc_valid = 1'b0, ra_zero = 1'b0, so_in = 1'b0;
    logic [63:0] ra_val = '0, rb_val = '0, rs_val = '0;
    logic [63:0] mem_addr, rt_data;
    logic        mem_re, mem_we, done;
    logic [31:0] mem_rdata, mem_wdata;
    logic [3:0]  cr_field;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    logic [31:0] model [16];
    assign mem_rdata = model[mem_addr[5:2]];
    always @(posedge clk) if (mem_we) model[mem_addr[5:2]] <= mem_wdata;

    lrsc_monitor dut (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .sc_valid(sc_valid),
        .ra_zero(ra_zero), .ra_val(ra_val), .rb_val(rb_val), .rs_val(rs_val),
        .so_in(so_in), .mem_addr(mem_addr), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .done(done), .cr_field(cr_field),
        .rt_data(rt_data)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic        raz;
        logic [63:0] ra;
        logic [63:0] rb;
        logic [63:0] rs;
        logic        so;
        logic        ok;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 1'b0, 64'h100, 64'h0, 64'h1111, 1'b0, 1'b0},               // R6 no reservation
        '{2'd1, 1'b1, 64'hFFFF, 64'h1000, 64'h0, 1'b0, 1'b0},              // R1 zero base, R2, R3
        '{2'd2, 1'b0, 64'h800, 64'h800, 64'hCAFE_0000_0000_2222, 1'b1, 1'b1}, // R4 exact, R7 so=1
        '{2'd2, 1'b0, 64'h800, 64'h800, 64'h3333, 1'b0, 1'b0},             // R8 repeat fails
        '{2'd1, 1'b0, 64'h2000, 64'h10, 64'h0, 1'b0, 1'b0},                // R3 load 0x2010
        '{2'd2, 1'b0, 64'h2000, 64'h18, 64'h4444, 1'b0, 1'b0},             // R5 same page mismatch
        '{2'd2, 1'b0, 64'h2000, 64'h10, 64'h5555, 1'b1, 1'b0},             // R8 cleared by previous
        '{2'd1, 1'b0, 64'h3000, 64'h4, 64'h0, 1'b0, 1'b0},                 // load 0x3004
        '{2'd1, 1'b0, 64'h5000, 64'h8, 64'h0, 1'b0, 1'b0},                 // R3 replaces with 0x5008
        '{2'd2, 1'b0, 64'h3000, 64'h4, 64'h6666, 1'b0, 1'b0},              // R5 other page, old addr
        '{2'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5008, 64'h0, 1'b0, 1'b0},
        '{2'd2, 1'b0, 64'hFFFF_FFFF_FFFF_F000, 64'h6008, 64'hABCD_7777, 1'b1, 1'b1}, // R1 wrap
        '{2'd1, 1'b0, 64'h20, 64'h20, 64'h0, 1'b0, 1'b0},
        '{2'd2, 1'b0, 64'h0, 64'h40, 64'hDEAD_BEEF_1234_5678, 1'b0, 1'b1}, // R4 low word stored
        '{2'd1, 1'b0, 64'h0, 64'h40, 64'h0, 1'b0, 1'b0}                    // R2 read back
    };

    task automatic chk(input bit good, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic [63:0] ea;
        logic [63:0] exp_rt;
        @(negedge clk);
        ld_valid = (v.op == 2'd1);
        sc_valid = (v.op == 2'd2);
        ra_zero  = v.raz;
        ra_val   = v.ra;
        rb_val   = v.rb;
        rs_val   = v.rs;
        so_in    = v.so;
        ea = (v.raz ? 64'h0 : v.ra) + v.rb;
        #1;
        chk(mem_addr == ea, "R1", mem_addr, ea);
        exp_rt = {32'h0, model[ea[5:2]]};
        if (v.op == 2'd1) begin
            chk(mem_re == 1'b1 && mem_we == 1'b0, "R2", {mem_re, mem_we}, 64'h2);
        end else begin
            chk(mem_we == v.ok, v.ok ? "R4" : "R5/R6", mem_we, v.ok);
            if (v.ok) chk(mem_wdata == v.rs[31:0], "R4", mem_wdata, v.rs[31:0]);
        end
        @(negedge clk);
        ld_valid = 1'b0;
        sc_valid = 1'b0;
        chk(done == 1'b1, "R9", done, 1);
        if (v.op == 2'd1)
            chk(rt_data == exp_rt, "R2", rt_data, exp_rt);
        else
            chk(cr_field == {2'b00, v.ok, v.so}, "R7", cr_field, {2'b00, v.ok, v.so});
        @(negedge clk);
        chk(done == 1'b0, "R9", done, 0);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 32'hA500_0000 + i;
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && cr_field == 4'h0 && rt_data == 64'h0, "R10", {done, cr_field}, 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R10: reset coinciding with a load-reserve
        @(negedge clk);
        rst = 1'b1;
        ld_valid = 1'b1;
        ra_zero = 1'b1;
        rb_val = 64'h70;
        @(negedge clk);
        ld_valid = 1'b0;
        rst = 1'b0;
        chk(done == 1'b0, "R10", done, 0);
        @(negedge clk);
        sc_valid = 1'b1;
        rs_val = 64'h99;
        so_in = 1'b0;
        #1;
        chk(mem_we == 1'b0, "R10", mem_we, 0);
        @(negedge clk);
        sc_valid = 1'b0;
        chk(cr_field == 4'b0000, "R10", cr_field, 0);

        // R10: reset clears held reservation
        run_vec('{2'd1, 1'b0, 64'h0, 64'h8, 64'h0, 1'b0, 1'b0});
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(rt_data == 64'h0 && done == 1'b0, "R10", rt_data, 0);
        run_vec('{2'd2, 1'b0, 64'h0, 64'h8, 64'h42, 1'b1, 1'b0});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule